// File: doc/BRIEF.md
# Audio Transmit Sample Buffer with Refill and Underrun Interrupts

This block holds the outgoing samples of a serial audio transmitter. A register write port pushes 32-bit sample words into a 32-entry first-in first-out store. The serializer takes words out one at a time. Words leave in the order in which they were written.

Software reads the current fill level. It sets a refill threshold, and a refill status is raised while the buffer has drained to that threshold or below. This lets an interrupt handler top the buffer up before it runs dry. If the serializer asks for a word while transfer is enabled and nothing is stored, an underrun flag is latched and the serializer is handed a zero word. Each of the two status outputs has its own enable. The underrun flag has a write-1 clear.

A transfer-start input must be high before any word may be taken out. A flush request empties the buffer at once. A busy indication then stays high for a fixed two cycles while software polls it, and pushes are ignored during that time.

Top module: `audtx_fifo`

## Requirements
- R1: After reset, `level` is 0, `flush_busy` is 0, `under_st` is 0 and `irq` is 0.
- R2: Each accepted push raises `level` by one. Each accepted pop lowers it by one. Popped words come out in push order. `pop_data` is valid in the same cycle as `pop_req`.
- R3: A push while `level` is 32 is dropped. `level` stays at 32, and the 32 stored words are unchanged.
- R4: While `xfer_start` is 0, `pop_req` removes nothing, and `pop_data` reads as 0.
- R5: `empty_st` is 1 exactly when `empty_ie` is 1 and `level` is less than or equal to the 5-bit `thresh`. `level` is a 6-bit count from 0 to 32.
- R6: If `pop_req` is high while `xfer_start` is 1 and `level` is 0, `pop_data` is 0 in that cycle and the underrun flag is set from the next cycle on. `under_st` shows the flag ANDed with `under_ie`, so a flag latched while the enable is off appears once the enable is turned on.
- R7: A cycle with `under_clr` high clears the underrun flag from the next cycle. If a new underrun occurs in the same cycle, the flag stays set.
- R8: A cycle with `flush_req` high makes `level` 0 from the next cycle. `flush_busy` is then 1 for exactly 2 cycles and returns to 0 without further input.
- R9: A push in the same cycle as `flush_req`, or while `flush_busy` is 1, is ignored.
- R10: A push and an accepted pop in the same cycle leave `level` unchanged and keep word order.
- R11: `irq` is the OR of `empty_st` and `under_st`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Transfer enable; pops are allowed only when set |
| wr_en | input | 1 | Push strobe from the register port |
| wr_data | input | 32 | Sample word to push |
| pop_req | input | 1 | Serializer request for the next word |
| pop_data | output | 32 | Word handed to the serializer; 0 when no word is taken |
| thresh | input | 5 | Refill threshold |
| empty_ie | input | 1 | Refill status enable |
| under_ie | input | 1 | Underrun status enable |
| under_clr | input | 1 | Write-1 clear of the underrun flag |
| flush_req | input | 1 | Flush request pulse |
| flush_busy | output | 1 | High while a flush is in progress |
| level | output | 6 | Current fill level, 0 to 32 |
| empty_st | output | 1 | Refill status (level at or below the threshold, enabled) |
| under_st | output | 1 | Underrun status (flag ANDed with its enable) |
| irq | output | 1 | Combined interrupt |

## Verification
Ordering is tried with a short run of distinct words, with a completely filled buffer plus one extra push, and with a push and a pop in the same cycle. Together these separate a correct pointer and count from an off-by-one at the wrap, a lost drop at the full level, and a miscounted simultaneous transfer. The threshold is compared against a level below it, a level equal to it and a level above it, with the enable both on and off, which catches a strict-versus-inclusive compare. Underrun is raised with its enable off and the enable is turned on later; it is then cleared, and finally a new underrun is raised in the same cycle as a clear. This separates a latched flag from a gated one and checks that a new underrun outranks the clear. A flush is issued with words stored and pushes attempted during the busy window, then followed by a normal push.

// File: rtl/audtx_fifo.sv
module audtx_fifo #(
  parameter int DEPTH     = 32,
  parameter int DW        = 32,
  parameter int FLUSH_CYC = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       xfer_start,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       pop_req,
  output logic [DW-1:0]              pop_data,
  input  logic [$clog2(DEPTH)-1:0]   thresh,
  input  logic                       empty_ie,
  input  logic                       under_ie,
  input  logic                       under_clr,
  input  logic                       flush_req,
  output logic                       flush_busy,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       empty_st,
  output logic                       under_st,
  output logic                       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam int FW = $clog2(FLUSH_CYC + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;
  logic [FW-1:0] fcnt;
  logic          uflag;

  wire is_empty = (cnt == '0);
  wire is_full  = (cnt == LW'(DEPTH));
  wire busy     = (fcnt != '0);
  wire push_ok  = wr_en & ~is_full & ~busy & ~flush_req;
  wire pop_ok   = pop_req & xfer_start & ~is_empty & ~busy & ~flush_req;
  wire under_ev = pop_req & xfer_start & is_empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush_req) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      cnt <= cnt + LW'(push_ok) - LW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         fcnt <= '0;
    else if (flush_req) fcnt <= FW'(FLUSH_CYC);
    else if (busy)      fcnt <= fcnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         uflag <= 1'b0;
    else if (under_ev)  uflag <= 1'b1;
    else if (under_clr) uflag <= 1'b0;
  end

  assign pop_data   = pop_ok ? mem[rptr] : '0;
  assign level      = cnt;
  assign flush_busy = busy;
  assign empty_st   = empty_ie & (cnt <= {1'b0, thresh});
  assign under_st   = uflag & under_ie;
  assign irq        = empty_st | under_st;
endmodule

module audtx_fifo_chk #(
  parameter int DEPTH = 32,
  parameter int DW    = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     xfer_start,
  input logic                     wr_en,
  input logic                     pop_req,
  input logic [DW-1:0]            pop_data,
  input logic                     under_ie,
  input logic                     flush_req,
  input logic                     flush_busy,
  input logic [$clog2(DEPTH):0]   level,
  input logic                     under_st
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH); // R3

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) == DEPTH && !(pop_req && xfer_start) && !flush_req) |=> int'(level) == DEPTH); // R3

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_req |=> (int'(level) <= int'($past(level)) + 1) && (int'(level) + 1 >= int'($past(level)))); // R2

  AST_NOSTART_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_start && !wr_en && !flush_req) |=> $stable(level)); // R4

  AST_UNDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && xfer_start && level == '0) |-> pop_data == '0); // R6

  AST_UNDER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && xfer_start && level == '0 && under_ie) |=> (under_st || !under_ie)); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (level == '0 && flush_busy)); // R8

  AST_BUSY_NOPUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_busy && !flush_req) |=> level == '0); // R9
endmodule

bind audtx_fifo audtx_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (.*);

// File: tb/audtx_fifo_tb.sv
module audtx_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_start = 1'b0, wr_en = 1'b0, pop_req = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] pop_data;
  logic [4:0]  thresh = '0;
  logic        empty_ie = 1'b0, under_ie = 1'b0, under_clr = 1'b0, flush_req = 1'b0;
  logic        flush_busy, empty_st, under_st, irq;
  logic [5:0]  level;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  audtx_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .wr_en(wr_en), .wr_data(wr_data),
    .pop_req(pop_req), .pop_data(pop_data), .thresh(thresh), .empty_ie(empty_ie),
    .under_ie(under_ie), .under_clr(under_clr), .flush_req(flush_req), .flush_busy(flush_busy),
    .level(level), .empty_st(empty_st), .under_st(under_st), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [31:0] w);
    wr_en = 1'b1; wr_data = w; step(); wr_en = 1'b0;
  endtask

  task automatic pop(output logic [31:0] d);
    pop_req = 1'b1; #1; d = pop_data; step(); pop_req = 1'b0;
  endtask

  task automatic flush();
    flush_req = 1'b1; step(); flush_req = 1'b0; step(); step();
  endtask

  task automatic t_reset();
    chk(level == 0, "R1 level", level, 0);
    chk(flush_busy == 0, "R1 flush_busy", flush_busy, 0);
    chk(under_st == 0 && irq == 0, "R1 under_st/irq", {under_st, irq}, 0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    xfer_start = 1'b1;
    for (int i = 0; i < 5; i++) push(32'h1000 + i * 7);
    chk(level == 5, "R2 level after 5 pushes", level, 5);
    for (int i = 0; i < 5; i++) begin
      pop(d);
      chk(d == 32'h1000 + i * 7, "R2 pop order", d, 32'h1000 + i * 7);
    end
    chk(level == 0, "R2 level after drain", level, 0);
  endtask

  task automatic t_full();
    logic [31:0] d;
    for (int i = 0; i < 33; i++) push(32'hA000_0000 + i);
    chk(level == 32, "R3 level saturates", level, 32);
    push(32'hDEAD_BEEF);
    chk(level == 32, "R3 level after extra push", level, 32);
    for (int i = 0; i < 32; i++) begin
      pop(d);
      chk(d == 32'hA000_0000 + i, "R3 stored word", d, 32'hA000_0000 + i);
    end
    chk(level == 0, "R3 drained", level, 0);
  endtask

  task automatic t_nostart();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) push(32'h55 + i);
    xfer_start = 1'b0;
    pop(d);
    chk(d == 0, "R4 pop_data without start", d, 0);
    chk(level == 3, "R4 level without start", level, 3);
    xfer_start = 1'b1;
    pop(d);
    chk(d == 32'h55, "R4 first word after start", d, 32'h55);
    flush();
  endtask

  task automatic t_thresh();
    empty_ie = 1'b1; thresh = 5'd4;
    for (int i = 0; i < 3; i++) push(i);
    chk(empty_st == 1, "R5 below threshold", empty_st, 1);
    push(3);
    chk(empty_st == 1, "R5 at threshold", empty_st, 1);
    chk(irq == 1, "R11 irq from empty_st", irq, 1);
    push(4);
    chk(empty_st == 0, "R5 above threshold", empty_st, 0);
    chk(irq == 0, "R11 irq low", irq, 0);
    thresh = 5'd5; #1;
    chk(empty_st == 1, "R5 raised threshold", empty_st, 1);
    empty_ie = 1'b0; #1;
    chk(empty_st == 0, "R5 disabled", empty_st, 0);
    flush();
  endtask

  task automatic t_under();
    logic [31:0] d;
    under_ie = 1'b0; xfer_start = 1'b1;
    pop(d);
    chk(d == 0, "R6 zero word on underrun", d, 0);
    chk(under_st == 0, "R6 gated by enable", under_st, 0);
    under_ie = 1'b1; #1;
    chk(under_st == 1, "R6 latched flag shown", under_st, 1);
    chk(irq == 1, "R11 irq from under_st", irq, 1);
    under_clr = 1'b1; step(); under_clr = 1'b0;
    chk(under_st == 0, "R7 cleared", under_st, 0);
    under_clr = 1'b1; pop_req = 1'b1; step(); under_clr = 1'b0; pop_req = 1'b0;
    chk(under_st == 1, "R7 set wins over clear", under_st, 1);
    under_clr = 1'b1; step(); under_clr = 1'b0;
    chk(under_st == 0, "R7 cleared again", under_st, 0);
  endtask

  task automatic t_flush();
    for (int i = 0; i < 6; i++) push(32'h77 + i);
    wr_en = 1'b1; wr_data = 32'h99; flush_req = 1'b1; step(); flush_req = 1'b0;
    chk(level == 0, "R8 level after flush", level, 0);
    chk(flush_busy == 1, "R8 busy cycle 1", flush_busy, 1);
    step();
    chk(level == 0, "R9 push ignored while busy", level, 0);
    chk(flush_busy == 1, "R8 busy cycle 2", flush_busy, 1);
    step(); wr_en = 1'b0;
    chk(level == 0, "R9 push ignored in last busy cycle", level, 0);
    chk(flush_busy == 0, "R8 busy self-clears", flush_busy, 0);
    push(32'h123);
    chk(level == 1, "R8 push after flush", level, 1);
    flush();
  endtask

  task automatic t_simul();
    logic [31:0] d;
    push(32'hB0); push(32'hB1);
    wr_en = 1'b1; wr_data = 32'hB2; pop_req = 1'b1; #1;
    chk(pop_data == 32'hB0, "R10 pop during push", pop_data, 32'hB0);
    step(); wr_en = 1'b0; pop_req = 1'b0;
    chk(level == 2, "R10 level unchanged", level, 2);
    pop(d); chk(d == 32'hB1, "R10 order word 1", d, 32'hB1);
    pop(d); chk(d == 32'hB2, "R10 order word 2", d, 32'hB2);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_order();
    t_full();
    t_nostart();
    t_thresh();
    t_under();
    t_flush();
    t_simul();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule